// File: doc/BRIEF.md
# Floating-Point Status Register with Exception and Compare Update

This block holds the 64-bit floating-point status word of an FPU. After each arithmetic operation, the datapath presents that operation's five raw IEEE flags with a strobe. The block then does one of two things:

- It raises a trap if any flag is enabled in the trap-enable mask.
- Otherwise it folds the flags into the accrued-exception history.

Compare results arrive on a separate strobe. Each one writes a 2-bit relation code into one of four condition-code fields, and the selected field is chosen per compare. An unordered result is an invalid-operation event. It traps if the invalid trap-enable bit is set, or if the compare is the signalling variant. In every other case it is recorded as accrued invalid.

A software write port loads the whole register. A one-cycle trap-request pulse and the trap-type field tell the pipeline that the last update wants a floating-point trap.

Register layout:

| Bits | Field |
|------|-------|
| 4:0 | current exceptions |
| 9:5 | accrued exceptions |
| 11:10 | condition-code field 0 |
| 16:14 | trap type (code 1 = IEEE exception) |
| 27:23 | trap-enable mask |
| 33:32 | condition-code field 1 |
| 35:34 | condition-code field 2 |
| 37:36 | condition-code field 3 |

Within each 5-bit exception group, the bits from high to low are: invalid, overflow, underflow, divide-by-zero, inexact.

Top module: `fpu_status_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `status` becomes all zero and `trap_req` becomes 0.
- R2: A flag strobe with a non-zero `flag_vec` replaces bits 4:0 with `flag_vec` (bit 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact).
- R3: If `flag_vec` AND bits 27:23 is non-zero, bits 16:14 become 1 and `trap_req` is high in the cycle after the strobe edge. Bits 9:5 are unchanged.
- R4: If no flag in `flag_vec` is enabled, bits 9:5 are ORed with `flag_vec`, bits 16:14 are kept, and no trap is requested.
- R5: A flag strobe with `flag_vec` equal to zero changes nothing and requests no trap.
- R6: A compare writes `cmp_rel` into the field selected by `cmp_sel`: 0 selects bits 11:10, 1 selects 33:32, 2 selects 35:34, 3 selects 37:36. Relation codes are 0 equal, 1 less, 2 greater, 3 unordered. No other field changes.
- R7: An unordered quiet compare (`cmp_signal`=0) with bit 27 clear sets bit 9. It leaves bits 4:0 and 16:14 unchanged and requests no trap.
- R8: An unordered compare with bit 27 set, or with `cmp_signal`=1, does four things: writes 3 into the field, sets bit 4, sets bits 16:14 to 1, and pulses `trap_req`.
- R9: An ordered compare, signalling or not, changes only its condition-code field and requests no trap.
- R10: A software write loads `sw_wdata` and requests no trap. Any flag or compare strobe in the same cycle is dropped.
- R11: When a compare and a flag strobe coincide, only the compare takes effect.
- R12: `trap_req` is high for exactly one cycle per trapping update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_valid | input | 1 | Raw flag vector valid |
| flag_vec | input | 5 | Raw IEEE flags of one operation |
| cmp_valid | input | 1 | Compare result valid |
| cmp_rel | input | 2 | Relation code |
| cmp_sel | input | 2 | Condition-code field select |
| cmp_signal | input | 1 | 1 for the signalling compare variant |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 64 | Software write data |
| status | output | 64 | Status register |
| trap_req | output | 1 | One-cycle trap request |
| trap_type | output | 3 | Trap-type field of the register |

## Verification
The trap and accrue paths are mutually exclusive and both depend on state that only software can set. Reaching the case where an unordered quiet compare traps therefore needs a software write that enables invalid first.

The bench steers into these cases by alternating register loads with operations. It also loads a trap-enable mask with only overflow set, then sends flags that mix enabled and disabled bits. Coincident strobes are driven in one cycle to exercise the priority rules.

// File: rtl/fsr_pkg.sv
// Shared constants and helpers for the floating-point status unit.
// Assumes a 64-bit register with fixed field positions.
package fsr_pkg;
    localparam int SR_W     = 64;
    localparam int FLAG_W   = 5;
    localparam int CEXC_LO  = 0;
    localparam int AEXC_LO  = CEXC_LO + FLAG_W;
    localparam int FCC_BASE = 10;
    localparam int FTT_LO   = 14;
    localparam int FTT_W    = 3;
    localparam int TEM_LO   = 23;
    localparam int NV_BIT   = FLAG_W - 1;
    localparam int CC_FIELDS = 4;
    localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Bit position of condition-code field k: base, or base + 20 + 2k.
    function automatic int fcc_pos(input int k);
        return (k == 0) ? FCC_BASE : FCC_BASE + 20 + 2 * k;
    endfunction
endpackage

// File: rtl/fsr_exc_eval.sv
// Evaluates one operation's raw IEEE flags against the trap-enable mask.
// Produces the new current and accrued fields and a trap decision.
// Assumes the flags belong to a single operation.
module fsr_exc_eval #(
    parameter int FLAG_W = 5
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] tem,
    input  logic [FLAG_W-1:0] aexc_cur,
    output logic [FLAG_W-1:0] cexc_nxt,
    output logic [FLAG_W-1:0] aexc_nxt,
    output logic              any_flag,
    output logic              trap_hit
);
    // Decide between trapping and accruing.
    always_comb begin
        any_flag = |flags;
        cexc_nxt = flags;
        trap_hit = any_flag && |(flags & tem);
        aexc_nxt = trap_hit ? aexc_cur : (aexc_cur | flags);
    end
endmodule

// File: rtl/fsr_cmp_eval.sv
// Applies one compare result to the status word: condition-code write,
// then the unordered invalid handling. Pure combinational.
module fsr_cmp_eval
    import fsr_pkg::*;
#(
    parameter int SR_W_P = 64
) (
    input  logic [SR_W_P-1:0] status_cur,
    input  logic [1:0]        rel,
    input  logic [1:0]        sel,
    input  logic              signalling,
    output logic [SR_W_P-1:0] status_nxt,
    output logic              trap_hit
);
    logic [CC_FIELDS-1:0] sel_hot;

    // One-hot field select, one term per condition-code field.
    for (genvar k = 0; k < CC_FIELDS; k++) begin : g_sel
        assign sel_hot[k] = (sel == k[1:0]);
    end

    // Clear and write the chosen field, then handle unordered results.
    always_comb begin
        status_nxt = status_cur;
        for (int k = 0; k < CC_FIELDS; k++) begin
            if (sel_hot[k]) begin
                status_nxt[fcc_pos(k) +: 2] = rel;
            end
        end
        trap_hit = 1'b0;
        if (rel == REL_UN) begin
            if (status_cur[TEM_LO + NV_BIT] || signalling) begin
                trap_hit = 1'b1;
                status_nxt[CEXC_LO + NV_BIT] = 1'b1;
                status_nxt[FTT_LO +: FTT_W] = FTT_IEEE;
            end else begin
                status_nxt[AEXC_LO + NV_BIT] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpu_status_unit.sv
// Floating-point status register. Updated by software writes, compare
// results and per-operation IEEE flags, in that priority order.
// Assumes at most one arithmetic operation's flags per strobe.
module fpu_status_unit
    import fsr_pkg::*;
#(
    parameter int WIDTH  = SR_W,
    parameter int NFLAGS = FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_valid,
    input  logic [NFLAGS-1:0] flag_vec,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_rel,
    input  logic [1:0]        cmp_sel,
    input  logic              cmp_signal,
    input  logic              sw_we,
    input  logic [WIDTH-1:0]  sw_wdata,
    output logic [WIDTH-1:0]  status,
    output logic              trap_req,
    output logic [2:0]        trap_type
);
    logic [WIDTH-1:0]  status_q;
    logic              trap_q;
    logic [NFLAGS-1:0] cexc_nxt, aexc_nxt;
    logic              any_flag, exc_trap;
    logic [WIDTH-1:0]  exc_status;
    logic [WIDTH-1:0]  cmp_status;
    logic              cmp_trap;

    fsr_exc_eval #(.FLAG_W(NFLAGS)) u_exc (
        .flags    (flag_vec),
        .tem      (status_q[TEM_LO +: NFLAGS]),
        .aexc_cur (status_q[AEXC_LO +: NFLAGS]),
        .cexc_nxt (cexc_nxt),
        .aexc_nxt (aexc_nxt),
        .any_flag (any_flag),
        .trap_hit (exc_trap)
    );

    fsr_cmp_eval #(.SR_W_P(WIDTH)) u_cmp (
        .status_cur (status_q),
        .rel        (cmp_rel),
        .sel        (cmp_sel),
        .signalling (cmp_signal),
        .status_nxt (cmp_status),
        .trap_hit   (cmp_trap)
    );

    // Assemble the status word after a flag update.
    always_comb begin
        exc_status = status_q;
        exc_status[CEXC_LO +: NFLAGS] = cexc_nxt;
        exc_status[AEXC_LO +: NFLAGS] = aexc_nxt;
        if (exc_trap) begin
            exc_status[FTT_LO +: FTT_W] = FTT_IEEE;
        end
    end

    // Register update with write > compare > flags priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            trap_q   <= 1'b0;
        end else if (sw_we) begin
            status_q <= sw_wdata;
            trap_q   <= 1'b0;
        end else if (cmp_valid) begin
            status_q <= cmp_status;
            trap_q   <= cmp_trap;
        end else if (flag_valid && any_flag) begin
            status_q <= exc_status;
            trap_q   <= exc_trap;
        end else begin
            trap_q   <= 1'b0;
        end
    end

    assign status    = status_q;
    assign trap_req  = trap_q;
    assign trap_type = status_q[FTT_LO +: FTT_W];
endmodule

// File: rtl/fpu_status_unit_chk.sv
// Property checker for fpu_status_unit, bound to every instance.
module fpu_status_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flag_valid,
    input logic [4:0]  flag_vec,
    input logic        cmp_valid,
    input logic [1:0]  cmp_rel,
    input logic [1:0]  cmp_sel,
    input logic        cmp_signal,
    input logic        sw_we,
    input logic [63:0] sw_wdata,
    input logic [63:0] status,
    input logic        trap_req,
    input logic [2:0]  trap_type
);
    // R3 / R8: a trap request always comes with the IEEE trap type.
    assert_trap_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_type == 3'd1);

    // R10: a software write loads the register and suppresses the trap.
    assert_sw_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (status == $past(sw_wdata)) && !trap_req);

    // R5: no effective strobe leaves the register alone.
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !cmp_valid && !(flag_valid && |flag_vec)) |=> $stable(status) && !trap_req);

    // R8: an unordered signalling compare always traps.
    assert_sig_unordered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && cmp_valid && cmp_signal && cmp_rel == 2'd3) |=> trap_req && status[4]);

    // R12: the trap request never lasts two cycles without a new strobe.
    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !cmp_valid && !flag_valid) |=> !trap_req);

    // R4 / R7: accrued bits are never cleared except by a software write.
    assert_accrue_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (status[9:5] & $past(status[9:5])) == $past(status[9:5]));
endmodule

bind fpu_status_unit fpu_status_unit_chk u_chk (.*);

// File: tb/fpu_status_unit_tb.sv
// Directed bench for fpu_status_unit: one task per scenario.
module fpu_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_valid = 1'b0;
    logic [4:0]  flag_vec = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [1:0]  cmp_sel = '0;
    logic        cmp_signal = 1'b0;
    logic        sw_we = 1'b0;
    logic [63:0] sw_wdata = '0;
    logic [63:0] status;
    logic        trap_req;
    logic [2:0]  trap_type;

    int total = 0;
    int bad = 0;
    logic [63:0] exp_s = '0;
    bit          exp_t = 1'b0;

    always #10 clk = ~clk;

    fpu_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .flag_valid(flag_valid), .flag_vec(flag_vec),
        .cmp_valid(cmp_valid), .cmp_rel(cmp_rel), .cmp_sel(cmp_sel),
        .cmp_signal(cmp_signal), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .status(status), .trap_req(trap_req), .trap_type(trap_type)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected effect of a flag strobe, from R2-R5.
    task automatic model_flags(input logic [4:0] f);
        exp_t = 1'b0;
        if (f != 5'd0) begin
            exp_s[4:0] = f;
            if ((f & exp_s[27:23]) != 5'd0) begin
                exp_s[16:14] = 3'd1;
                exp_t = 1'b1;
            end else begin
                exp_s[9:5] = exp_s[9:5] | f;
            end
        end
    endtask

    // Expected effect of a compare, from R6-R9.
    task automatic model_cmp(input logic [1:0] rel, input logic [1:0] sel, input bit sig);
        int pos;
        pos = (sel == 2'd0) ? 10 : 30 + 2 * int'(sel);
        exp_s[pos +: 2] = rel;
        exp_t = 1'b0;
        if (rel == 2'd3) begin
            if (exp_s[27] || sig) begin
                exp_s[4] = 1'b1;
                exp_s[16:14] = 3'd1;
                exp_t = 1'b1;
            end else begin
                exp_s[9] = 1'b1;
            end
        end
    endtask

    // Drive one cycle of strobes, then check the result and the pulse end.
    task automatic apply(input bit fv, input logic [4:0] f, input bit cv,
                         input logic [1:0] rel, input logic [1:0] sel, input bit sig,
                         input bit we, input logic [63:0] wd, input string tag);
        @(negedge clk);
        flag_valid = fv; flag_vec = f; cmp_valid = cv; cmp_rel = rel;
        cmp_sel = sel; cmp_signal = sig; sw_we = we; sw_wdata = wd;
        @(negedge clk);
        flag_valid = 0; flag_vec = '0; cmp_valid = 0; sw_we = 0;
        check(status, exp_s, {tag, " status"});
        check({63'd0, trap_req}, {63'd0, exp_t}, {tag, " trap_req"});
        @(negedge clk);
        check({63'd0, trap_req}, 64'd0, "R12 trap_req single cycle");
    endtask

    task automatic t_write(input logic [63:0] d);
        exp_s = d; exp_t = 1'b0;
        apply(0, '0, 0, 0, 0, 0, 1, d, "R10 sw write");
    endtask

    task automatic t_flags(input logic [4:0] f, input string tag);
        model_flags(f);
        apply(1, f, 0, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic t_cmp(input logic [1:0] rel, input logic [1:0] sel, input bit sig, input string tag);
        model_cmp(rel, sel, sig);
        apply(0, '0, 1, rel, sel, sig, 0, '0, tag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(status, 64'd0, "R1 reset status");
        check({63'd0, trap_req}, 64'd0, "R1 reset trap_req");
    endtask

    task automatic t_write_beats_cmp;
        exp_s = 64'h0000_0000_0800_0000; exp_t = 1'b0;
        apply(1, 5'h1f, 1, 2'd3, 2'd0, 1, 1, exp_s, "R10 write over strobes");
    endtask

    task automatic t_cmp_beats_flags;
        model_cmp(2'd1, 2'd2, 0);
        apply(1, 5'h01, 1, 2'd1, 2'd2, 0, 0, '0, "R11 compare over flags");
    endtask

    initial begin
        #(20 * 5000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_write(64'd0);
        t_flags(5'b00101, "R2 R4 accrue");
        t_flags(5'b00000, "R5 zero flags");
        t_flags(5'b10010, "R4 accrue more");
        t_write(64'h0000_0000_0400_0000 | exp_s);
        t_flags(5'b01001, "R3 overflow trap");
        t_flags(5'b00001, "R4 disabled flag");
        t_write(64'd0);
        t_cmp(2'd0, 2'd0, 0, "R6 eq field0");
        t_cmp(2'd1, 2'd1, 0, "R6 lt field1");
        t_cmp(2'd2, 2'd2, 0, "R6 gt field2");
        t_cmp(2'd1, 2'd3, 0, "R6 lt field3");
        t_cmp(2'd2, 2'd0, 0, "R6 overwrite field0");
        t_cmp(2'd3, 2'd1, 0, "R7 quiet unordered");
        t_cmp(2'd2, 2'd1, 1, "R9 signalling ordered");
        t_cmp(2'd3, 2'd2, 1, "R8 signalling unordered");
        t_write(64'h0000_0000_0800_0000);
        t_cmp(2'd3, 2'd3, 0, "R8 quiet unordered enabled");
        t_write_beats_cmp();
        t_cmp_beats_flags();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule